// File: doc/BRIEF.md
# Preamble and Sync Raw Bit Receiver

This block is the receive front end used when packet handling is switched off. It watches a recovered serial bit stream, presented one bit per strobe. It first waits for a run of alternating bits of programmable length, then for a 16-bit sync word. After the sync word it streams every following bit, packed into bytes, to a FIFO write port. It applies no length, header, whitening or CRC qualification to those bits.

An optional Manchester decoder sits in front of the preamble and sync search, so that preamble, sync and data are all judged on decoded bits. Reception runs until a re-arm pulse sends the block back to preamble search. Status outputs report preamble lock, sync lock, a Manchester coding error and a FIFO overflow.

Top module: `raw_sync_rx`

## Requirements
- R1: After reset, pre_det_o, sync_det_o, fifo_we_o, manch_err_o and overflow_o are all 0.
- R2: pre_det_o rises after the strobe that completes a run of pre_thresh_i consecutive alternating decoded bits. A decoded bit equal to its predecessor restarts the run, counting itself as its first bit.
- R3: While pre_det_o is high and sync_det_o is low, sync_det_o rises after the strobe at which the last 16 decoded bits, all received after preamble lock and taken oldest as bit 15, equal sync_word_i.
- R4: If no sync match occurs by the 32nd decoded bit after preamble lock, pre_det_o falls after that bit. A match on the 32nd bit itself still sets sync_det_o.
- R5: After sync lock the decoded bits are packed MSB first. fifo_we_o pulses for one cycle, carrying the byte on fifo_wdata_o, in the cycle after the clock edge that accepts the 8th bit of each byte.
- R6: With manch_en_i = 1, raw bits are taken in pairs, first then second, with pairing starting at the first strobe after reset or re-arm. The pair 1 then 0 decodes to 1, and 0 then 1 decodes to 0.
- R7: An invalid Manchester pair (00 or 11) after preamble lock sets the sticky manch_err_o, drops the partial byte and returns the block to preamble search. During preamble search it sets no flag, resets the run, and reuses its second bit as the first half of the next pair.
- R8: When a byte completes while fifo_full_i is 1, fifo_we_o stays 0, the byte is lost and the sticky overflow_o is set.
- R9: A re-arm pulse returns the block to preamble search and clears manch_err_o, overflow_o and any partial byte. It takes priority over a byte that completes in the same cycle.
- R10: bit_i has no effect in cycles where bit_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered serial bit |
| bit_valid_i | input | 1 | Strobe qualifying bit_i |
| pre_thresh_i | input | 6 | Alternating run length needed for preamble lock |
| sync_word_i | input | 16 | Sync word to match |
| manch_en_i | input | 1 | Enable Manchester decoding |
| rearm_i | input | 1 | Return to preamble search and clear flags |
| fifo_full_i | input | 1 | FIFO cannot accept a write |
| fifo_wdata_o | output | 8 | Byte to write |
| fifo_we_o | output | 1 | FIFO write strobe |
| pre_det_o | output | 1 | Preamble locked (sync search or data) |
| sync_det_o | output | 1 | Sync locked, data streaming |
| manch_err_o | output | 1 | Sticky Manchester pair error |
| overflow_o | output | 1 | Sticky FIFO overflow |

## Verification
Two collisions are provoked on purpose. In the first, the bench raises the re-arm pulse in the same cycle as the strobe carrying the 8th bit of a byte. It then checks that no write strobe appears and that sync lock is gone. In the second, the sync word is placed so that its last bit is exactly the 32nd bit after preamble lock, where the window expiry and the match coincide; the match must win and sync lock must be seen. A neighbouring case sends 32 bits with no match and expects preamble lock to drop on the last of them.

// File: rtl/raw_rx_pkg.sv
package raw_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_manch_dec.sv
module rx_manch_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  input  logic en_i,
  input  logic slip_i,
  input  logic clr_i,
  output logic dec_bit_o,
  output logic dec_valid_o,
  output logic pair_err_o
);
  logic half_q, have_q;
  logic pair_done;

  assign pair_done   = en_i & bit_valid_i & have_q;
  assign pair_err_o  = pair_done & (half_q == bit_i);
  assign dec_valid_o = en_i ? (pair_done & (half_q != bit_i)) : bit_valid_i;
  assign dec_bit_o   = en_i ? half_q : bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      have_q <= 1'b0;
    end else if (bit_valid_i) begin
      if (!have_q) begin
        have_q <= 1'b1;
        half_q <= bit_i;
      end else if (pair_err_o && slip_i) begin
        // realign by one bit while hunting
        half_q <= bit_i;
      end else begin
        have_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_pre_det.sv
module rx_pre_det #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic             bit_i,
  input  logic             err_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] run_q, run_nxt;
  logic             prev_q;

  always_comb begin
    if (run_q == '0)           run_nxt = CNT_W'(1);
    else if (bit_i == prev_q)  run_nxt = CNT_W'(1);
    else if (run_q == CntMax)  run_nxt = CntMax;
    else                       run_nxt = run_q + CNT_W'(1);
  end

  assign hit_o = valid_i & (run_nxt >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (clr_i || err_i) begin
      run_q <= '0;
    end else if (valid_i) begin
      run_q  <= run_nxt;
      prev_q <= bit_i;
    end
  end
endmodule

// File: rtl/rx_sync_srch.sv
module rx_sync_srch #(
  parameter int SYNC_W   = 16,
  parameter int SYNC_WIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic [SYNC_W-1:0] word_i,
  output logic              match_o,
  output logic              expire_o
);
  localparam int WIN_W = $clog2(SYNC_WIN + 1);

  logic [SYNC_W-1:0] sreg_q, sreg_nxt;
  logic [WIN_W-1:0]  win_q;
  logic              go;

  assign go       = active_i & valid_i;
  assign sreg_nxt = {sreg_q[SYNC_W-2:0], bit_i};
  assign match_o  = go & (win_q >= WIN_W'(SYNC_W - 1)) & (sreg_nxt == word_i);
  assign expire_o = go & ~match_o & (win_q == WIN_W'(SYNC_WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      win_q  <= '0;
    end else if (!active_i) begin
      sreg_q <= '0;
      win_q  <= '0;
    end else if (valid_i) begin
      sreg_q <= sreg_nxt;
      win_q  <= win_q + WIN_W'(1);
    end
  end
endmodule

// File: rtl/rx_byte_pack.sv
module rx_byte_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ovf_clr_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic              fifo_full_i,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              ovf_o
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [BC_W-1:0]   cnt_q;
  logic              pend_q;
  logic              last;

  assign last    = valid_i & (cnt_q == BC_W'(BYTE_W - 1));
  assign wdata_o = sh_q;
  assign we_o    = pend_q & ~fifo_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= last;
      if (valid_i) begin
        sh_q  <= {sh_q[BYTE_W-2:0], bit_i};
        cnt_q <= last ? '0 : cnt_q + BC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ovf_o <= 1'b0;
    else if (ovf_clr_i)             ovf_o <= 1'b0;
    else if (pend_q && fifo_full_i) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/raw_sync_rx.sv
module raw_sync_rx
  import raw_rx_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SYNC_W   = 16,
  parameter int SYNC_WIN = 32,
  parameter int BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic [CNT_W-1:0]  pre_thresh_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic              manch_en_i,
  input  logic              rearm_i,
  input  logic              fifo_full_i,
  output logic [BYTE_W-1:0] fifo_wdata_o,
  output logic              fifo_we_o,
  output logic              pre_det_o,
  output logic              sync_det_o,
  output logic              manch_err_o,
  output logic              overflow_o
);
  rx_state_e st_q, st_d;
  logic dec_bit, dec_valid, pair_err;
  logic in_hunt, in_sync, in_data;
  logic pre_hit, sync_hit, sync_exp;
  logic err_q;

  assign in_hunt = (st_q == ST_HUNT);
  assign in_sync = (st_q == ST_SYNC);
  assign in_data = (st_q == ST_DATA);

  rx_manch_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .en_i        (manch_en_i),
    .slip_i      (in_hunt),
    .clr_i       (rearm_i),
    .dec_bit_o   (dec_bit),
    .dec_valid_o (dec_valid),
    .pair_err_o  (pair_err)
  );

  rx_pre_det #(.CNT_W(CNT_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rearm_i | ~in_hunt),
    .valid_i  (dec_valid & in_hunt),
    .bit_i    (dec_bit),
    .err_i    (pair_err & in_hunt),
    .thresh_i (pre_thresh_i),
    .hit_o    (pre_hit)
  );

  rx_sync_srch #(.SYNC_W(SYNC_W), .SYNC_WIN(SYNC_WIN)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_sync & ~rearm_i),
    .valid_i  (dec_valid),
    .bit_i    (dec_bit),
    .word_i   (sync_word_i),
    .match_o  (sync_hit),
    .expire_o (sync_exp)
  );

  rx_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rearm_i | ~in_data),
    .ovf_clr_i   (rearm_i),
    .valid_i     (dec_valid & in_data),
    .bit_i       (dec_bit),
    .fifo_full_i (fifo_full_i),
    .wdata_o     (fifo_wdata_o),
    .we_o        (fifo_we_o),
    .ovf_o       (overflow_o)
  );

  always_comb begin
    st_d = st_q;
    if (rearm_i) begin
      st_d = ST_HUNT;
    end else begin
      unique case (st_q)
        ST_HUNT: if (pre_hit) st_d = ST_SYNC;
        ST_SYNC: begin
          if (pair_err || sync_exp) st_d = ST_HUNT;
          else if (sync_hit)        st_d = ST_DATA;
        end
        ST_DATA: if (pair_err) st_d = ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (rearm_i)                 err_q <= 1'b0;
      else if (pair_err && !in_hunt) err_q <= 1'b1;
    end
  end

  assign pre_det_o   = ~in_hunt;
  assign sync_det_o  = in_data;
  assign manch_err_o = err_q;
endmodule

// File: rtl/raw_sync_rx_chk.sv
module raw_sync_rx_chk #(
  parameter int CNT_W  = 6,
  parameter int SYNC_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_i,
  input logic              bit_valid_i,
  input logic [CNT_W-1:0]  pre_thresh_i,
  input logic [SYNC_W-1:0] sync_word_i,
  input logic              manch_en_i,
  input logic              rearm_i,
  input logic              fifo_full_i,
  input logic [BYTE_W-1:0] fifo_wdata_o,
  input logic              fifo_we_o,
  input logic              pre_det_o,
  input logic              sync_det_o,
  input logic              manch_err_o,
  input logic              overflow_o
);
  a_r2_lock_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_det_o) |-> $past(bit_valid_i));

  a_r3_sync_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_det_o) |-> $past(pre_det_o));

  a_r3_sync_implies_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_det_o |-> pre_det_o);

  a_r5_write_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> sync_det_o);

  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |=> !fifo_we_o);

  a_r7_err_needs_manch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(manch_err_o) |-> $past(manch_en_i));

  a_r8_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> !fifo_full_i);

  a_r8_ovf_from_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(fifo_full_i));

  a_r9_rearm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (!pre_det_o && !manch_err_o && !overflow_o));
endmodule

bind raw_sync_rx raw_sync_rx_chk #(.CNT_W(CNT_W), .SYNC_W(SYNC_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_i        (bit_i),
  .bit_valid_i  (bit_valid_i),
  .pre_thresh_i (pre_thresh_i),
  .sync_word_i  (sync_word_i),
  .manch_en_i   (manch_en_i),
  .rearm_i      (rearm_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_wdata_o (fifo_wdata_o),
  .fifo_we_o    (fifo_we_o),
  .pre_det_o    (pre_det_o),
  .sync_det_o   (sync_det_o),
  .manch_err_o  (manch_err_o),
  .overflow_o   (overflow_o)
);

// File: tb/tb_raw_sync_rx.sv
module tb_raw_sync_rx;
  localparam logic [15:0] SYNC = 16'h2DD4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic [5:0] pre_thresh_i = 6'd8;
  logic       manch_en_i = 1'b0;
  logic       rearm_i = 1'b0;
  logic       fifo_full_i = 1'b0;
  logic [7:0] fifo_wdata_o;
  logic       fifo_we_o, pre_det_o, sync_det_o, manch_err_o, overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] cap [0:15];
  int cap_n = 0;

  always #5 clk_i = ~clk_i;

  raw_sync_rx dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .bit_valid_i  (bit_valid_i),
    .pre_thresh_i (pre_thresh_i),
    .sync_word_i  (SYNC),
    .manch_en_i   (manch_en_i),
    .rearm_i      (rearm_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_wdata_o (fifo_wdata_o),
    .fifo_we_o    (fifo_we_o),
    .pre_det_o    (pre_det_o),
    .sync_det_o   (sync_det_o),
    .manch_err_o  (manch_err_o),
    .overflow_o   (overflow_o)
  );

  always @(negedge clk_i) begin
    if (fifo_we_o && cap_n < 16) begin
      cap[cap_n] = fifo_wdata_o;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one strobe, then an idle cycle with a flipped bit (R10)
  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b;
    bit_valid_i = 1'b1;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    bit_i = ~b;
  endtask

  task automatic send_sym(input logic b);
    if (manch_en_i) begin
      send_bit(b);
      send_bit(~b);
    end else begin
      send_bit(b);
    end
  endtask

  task automatic rearm();
    @(negedge clk_i);
    rearm_i = 1'b1;
    @(negedge clk_i);
    rearm_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int j = 7; j >= 0; j--) send_sym(b[j]);
  endtask

  task automatic lock(input int th);
    for (int i = 0; i < th; i++) send_sym(~i[0]);
    for (int i = 15; i >= 0; i--) send_sym(SYNC[i]);
  endtask

  function automatic logic [7:0] pat(input int th, input int m, input int k);
    return 8'((th * 29 + m * 101 + k * 67 + 13) & 255);
  endfunction

  initial begin
    while (1) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 pre_det", pre_det_o, 0);
    check("R1 sync_det", sync_det_o, 0);
    check("R1 we", fifo_we_o, 0);
    check("R1 err", manch_err_o, 0);
    check("R1 ovf", overflow_o, 0);

    // sweep thresholds and coding
    for (int ti = 0; ti < 4; ti++) begin
      for (int m = 0; m < 2; m++) begin
        int th;
        th = 4 << ti;
        pre_thresh_i = 6'(th);
        manch_en_i = m[0];
        rearm();
        cap_n = 0;
        for (int i = 0; i < th - 1; i++) send_sym(~i[0]);
        check($sformatf("R2 below thr th=%0d m=%0d", th, m), pre_det_o, 0);
        send_sym(~(th - 1) & 1);
        check($sformatf("R2 at thr th=%0d m=%0d", th, m), pre_det_o, 1);
        for (int i = 15; i >= 1; i--) send_sym(SYNC[i]);
        check($sformatf("R3 before last th=%0d m=%0d", th, m), sync_det_o, 0);
        send_sym(SYNC[0]);
        check($sformatf("R3 matched th=%0d m=%0d", th, m), sync_det_o, 1);
        for (int k = 0; k < 3; k++) send_byte(pat(th, m, k));
        @(negedge clk_i);
        check($sformatf("R5 count th=%0d m=%0d", th, m), cap_n, 3);
        for (int k = 0; k < 3; k++)
          check($sformatf("%s byte%0d th=%0d", m ? "R6" : "R5", k, th), cap[k], pat(th, m, k));
        if (m == 1) begin
          send_bit(1'b1);
          send_bit(1'b1);
          check("R7 err flag", manch_err_o, 1);
          check("R7 back to hunt", pre_det_o, 0);
        end
        rearm();
        check("R9 pre cleared", pre_det_o, 0);
        check("R9 err cleared", manch_err_o, 0);
      end
    end

    // R2 broken run restarts
    manch_en_i = 1'b0;
    pre_thresh_i = 6'd8;
    rearm();
    send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    send_bit(1);
    for (int i = 0; i < 6; i++) send_bit(i[0]);
    check("R2 restart below", pre_det_o, 0);
    send_bit(0);
    check("R2 restart lock", pre_det_o, 1);

    // R4 expiry on 32nd bit
    rearm();
    for (int i = 0; i < 8; i++) send_bit(~i[0]);
    for (int i = 0; i < 31; i++) send_bit(1'b0);
    check("R4 still locked at 31", pre_det_o, 1);
    send_bit(1'b0);
    check("R4 expired at 32", pre_det_o, 0);

    // R4 match on the 32nd bit wins
    rearm();
    for (int i = 0; i < 8; i++) send_bit(~i[0]);
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    for (int i = 15; i >= 1; i--) send_bit(SYNC[i]);
    check("R4 not yet", sync_det_o, 0);
    send_bit(SYNC[0]);
    check("R4 match at 32", sync_det_o, 1);

    // R8 overflow
    cap_n = 0;
    fifo_full_i = 1'b1;
    send_byte(8'h5A);
    @(negedge clk_i);
    fifo_full_i = 1'b0;
    check("R8 no write", cap_n, 0);
    check("R8 ovf set", overflow_o, 1);
    send_byte(8'hC3);
    @(negedge clk_i);
    check("R8 next count", cap_n, 1);
    check("R8 next byte", cap[0], 8'hC3);
    check("R8 ovf sticky", overflow_o, 1);

    // R9 rearm same cycle as 8th bit
    for (int j = 7; j >= 1; j--) send_bit(j[0]);
    @(negedge clk_i);
    bit_i = 1'b1;
    bit_valid_i = 1'b1;
    rearm_i = 1'b1;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    rearm_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 byte dropped", cap_n, 1);
    check("R9 sync cleared", sync_det_o, 0);
    check("R9 ovf cleared", overflow_o, 0);

    // R7 slip in hunt: raw 1 1 then 0 01 10 01 -> 1 0 1 0
    manch_en_i = 1'b1;
    pre_thresh_i = 6'd4;
    rearm();
    send_bit(1); send_bit(1);
    check("R7 no flag in hunt", manch_err_o, 0);
    send_bit(0);
    send_bit(0); send_bit(1);
    send_bit(1); send_bit(0);
    check("R7 slip below", pre_det_o, 0);
    send_bit(0); send_bit(1);
    check("R7 slip lock", pre_det_o, 1);
    check("R7 still no flag", manch_err_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule